// File: doc/BRIEF.md
# Monochrome framebuffer pixel serializer

This block feeds a raster display from a one-bit-per-pixel frame memory. It reads the frame memory one word at a time through a read-only port and unloads each word onto a serial video line, one pixel per clock. A separate timing generator drives it with three strobes. The first marks the start of each line. The second marks the start of each frame. The third is a display-enable level that is high only while pixels are visible. Memory traffic runs at one read per word, so a 16-bit word costs one access per sixteen pixel clocks. The video line is held dark during horizontal and vertical blanking.

At each start of line the block reads the first word of the line during blanking, so that the first visible pixel is ready on the first enabled clock. The block then prefetches each following word while the current word is still shifting out. The word address runs linearly through the frame. It returns to zero at start of frame and moves forward only when a line actually displays.

Top module: `fb_bit_serializer`

## Requirements
- R1: During display-enable, pixel k of the n-th displayed line since start of frame equals bit (WORD_W-1 - k mod WORD_W) of the memory word at address n*(H_PIX/WORD_W) + k/WORD_W. The most significant bit is the leftmost pixel.
- R2: A start-of-line strobe in cycle t produces rd_o high in cycle t+1. The address is then (lines displayed since the last start of frame)*(H_PIX/WORD_W). With start of frame in the same cycle, the address is 0.
- R3: Within a displayed line, a read of the next consecutive word is issued in the cycle where the current word's bit 2 (counting the last bit as bit 0) is shown. No read follows the last word of the line.
- R4: video_o is 0 in every cycle in which de_i is 0.
- R5: rd_o is never high in two consecutive cycles. Outside displayed lines, rd_o is high only in the cycle after a start-of-line strobe.
- R6: While rst_ni is low, rd_o, addr_o and video_o are 0.
- R7: The memory answers a read in the following cycle. rdata_i holds the word of the address presented with rd_o one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sol_i | input | 1 | Start-of-line strobe, one cycle, in blanking |
| sof_i | input | 1 | Start-of-frame strobe, with the first line's sol_i |
| de_i | input | 1 | Display enable, high for visible pixels |
| rdata_i | input | WORD_W | Read data from frame memory |
| rd_o | output | 1 | Memory read strobe |
| addr_o | output | ADDR_W | Memory word address |
| video_o | output | 1 | Serial pixel output |

## Verification
The properties take for granted a well-formed raster. sol_i is a single-cycle pulse in blanking, at least four cycles ahead of display-enable. sof_i only ever comes together with sol_i. Display-enable stays high for exactly H_PIX consecutive cycles on a displayed line. The bench raster generator meets these by construction. It places the line strobe at the start of each line, sets eight blanking cycles before the enable window, and runs three frames. Each frame has blank lines both before and after the displayed lines, so the address wrap at start of frame and the idle fetches on blank lines are both exercised.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef enum logic {FK_HEAD = 1'b0, FK_RUN = 1'b1} fetch_kind_e;
endpackage

// File: rtl/fbs_fetch.sv
module fbs_fetch
  import fbs_pkg::*;
#(
  parameter int unsigned WPL    = 64,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sol_i,
  input  logic              sof_i,
  input  logic              de_i,
  input  logic              run_slot_i,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output fetch_kind_e       kind_o
);
  localparam int unsigned CW = $clog2(WPL + 1);
  localparam logic [CW-1:0] WPL_C = CW'(WPL);

  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     wcnt_q;
  logic              de_q;
  logic              req_head, req_run, commit;

  assign req_head = sol_i;
  assign req_run  = run_slot_i && !sol_i && (wcnt_q < WPL_C);
  // first word of a line is only counted once the line actually shows
  assign commit   = de_i && !de_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wcnt_q <= '0;
      de_q   <= 1'b0;
      rd_o   <= 1'b0;
      addr_o <= '0;
      kind_o <= FK_HEAD;
    end else begin
      de_q   <= de_i;
      rd_o   <= req_head || req_run;
      kind_o <= req_head ? FK_HEAD : FK_RUN;
      if (req_head)     addr_o <= sof_i ? '0 : addr_q;
      else if (req_run) addr_o <= addr_q;
      if (sof_i)                  addr_q <= '0;
      else if (commit || req_run) addr_q <= addr_q + 1'b1;
      if (req_head)     wcnt_q <= CW'(1);
      else if (req_run) wcnt_q <= wcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fbs_land.sv
module fbs_land
  import fbs_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  fetch_kind_e       kind_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              head_vld_o,
  output logic [WORD_W-1:0] nxt_o
);
  logic        rd_d;
  fetch_kind_e kind_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_d   <= 1'b0;
      kind_d <= FK_HEAD;
      nxt_o  <= '0;
    end else begin
      rd_d   <= rd_i;
      kind_d <= kind_i;
      if (rd_d && kind_d == FK_RUN) nxt_o <= rdata_i;
    end
  end

  assign head_vld_o = rd_d && (kind_d == FK_HEAD);
endmodule

// File: rtl/fbs_shift.sv
module fbs_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              de_i,
  input  logic              head_vld_i,
  input  logic [WORD_W-1:0] head_word_i,
  input  logic [WORD_W-1:0] nxt_i,
  output logic              run_slot_o,
  output logic              video_o
);
  localparam int unsigned BW = $clog2(WORD_W);
  localparam logic [BW-1:0] LAST = BW'(WORD_W - 1);
  // request slot leaves fetch, memory and landing registers before the reload
  localparam logic [BW-1:0] SLOT = BW'(WORD_W - 4);

  logic [WORD_W-1:0] sr_q;
  logic [BW-1:0]     cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (head_vld_i) begin
      sr_q  <= head_word_i;
      cnt_q <= '0;
    end else if (de_i) begin
      if (cnt_q == LAST) begin
        sr_q  <= nxt_i;
        cnt_q <= '0;
      end else begin
        sr_q  <= {sr_q[WORD_W-2:0], 1'b0};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign run_slot_o = de_i && (cnt_q == SLOT);
  assign video_o    = de_i && sr_q[WORD_W-1];
endmodule

// File: rtl/fb_bit_serializer.sv
module fb_bit_serializer
  import fbs_pkg::*;
#(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned H_PIX   = 1024,
  parameter int unsigned V_LINES = 768,
  parameter int unsigned ADDR_W  = $clog2((H_PIX / WORD_W) * V_LINES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sol_i,
  input  logic              sof_i,
  input  logic              de_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              video_o
);
  localparam int unsigned WPL = H_PIX / WORD_W;

  fetch_kind_e       kind;
  logic              run_slot, head_vld;
  logic [WORD_W-1:0] nxt;

  fbs_fetch #(.WPL(WPL), .ADDR_W(ADDR_W)) u_fetch (
    .clk_i, .rst_ni, .sol_i, .sof_i, .de_i,
    .run_slot_i (run_slot),
    .rd_o, .addr_o,
    .kind_o     (kind)
  );

  fbs_land #(.WORD_W(WORD_W)) u_land (
    .clk_i, .rst_ni,
    .rd_i       (rd_o),
    .kind_i     (kind),
    .rdata_i,
    .head_vld_o (head_vld),
    .nxt_o      (nxt)
  );

  fbs_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i, .rst_ni, .de_i,
    .head_vld_i  (head_vld),
    .head_word_i (rdata_i),
    .nxt_i       (nxt),
    .run_slot_o  (run_slot),
    .video_o
  );
endmodule

// File: rtl/fb_bit_serializer_chk.sv
module fb_bit_serializer_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sol_i,
  input logic              sof_i,
  input logic              de_i,
  input logic              rd_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              video_o
);
  // R4
  dark_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_i |-> !video_o);
  // R2
  head_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol_i |=> rd_o);
  // R2
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sol_i && sof_i) |=> (rd_o && addr_o == '0));
  // R5
  blank_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!de_i && !sol_i) |=> !rd_o);
  // R5
  rd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> !rd_o);
  // R6
  always_comb begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!rd_o && addr_o == '0 && !video_o);
    end
  end
endmodule

bind fb_bit_serializer fb_bit_serializer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .sol_i, .sof_i, .de_i, .rd_o, .addr_o, .video_o
);

// File: tb/sim_fb_bit_serializer.sv
module sim_fb_bit_serializer;
  localparam int W      = 16;
  localparam int HP     = 64;
  localparam int VL     = 4;
  localparam int WPL    = HP / W;
  localparam int AW     = $clog2(WPL * VL + 1);
  localparam int HB     = 8;
  localparam int HTOT   = HP + 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sol = 1'b0, sof = 1'b0, de = 1'b0;
  logic [W-1:0]  rdata = '0;
  logic          rd;
  logic [AW-1:0] addr;
  logic          video;
  int            n_cmp = 0, n_err = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  fb_bit_serializer #(.WORD_W(W), .H_PIX(HP), .V_LINES(VL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sol_i(sol), .sof_i(sof), .de_i(de),
    .rdata_i(rdata), .rd_o(rd), .addr_o(addr), .video_o(video)
  );

  function automatic logic [W-1:0] word_at(input int a);
    return W'(a * 40503 + 15450) ^ W'(a << 11);
  endfunction

  // R7: registered read port
  always @(posedge clk) if (rd) rdata <= word_at(int'(addr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  task automatic run_line(input bit f, input bit act, input int aline, input int ldone);
    for (int h = 0; h < HTOT; h++) begin
      @(negedge clk);
      sol = (h == 0);
      sof = f && (h == 0);
      de  = act && (h >= HB) && (h < HB + HP);
      #1;
      if (h == 1) begin
        // R2 head fetch address
        chk(rd == 1'b1, "R2 rd", int'(rd), 1);
        chk(int'(addr) == ldone * WPL, "R2 addr", int'(addr), ldone * WPL);
      end else if (act) begin
        // R3 one run fetch per word, at its bit-2 cycle, none after the last word
        int  rel = h - (HB + W - 3);
        bit  exp_rd = (rel >= 0) && (rel % W == 0) && (rel / W <= WPL - 2);
        chk(rd == exp_rd, "R3 rd", int'(rd), int'(exp_rd));
        if (exp_rd)
          chk(int'(addr) == aline * WPL + rel / W + 1, "R3 addr", int'(addr),
              aline * WPL + rel / W + 1);
      end else begin
        // R5 no reads on blank lines beyond the head fetch
        chk(rd == 1'b0, "R5", int'(rd), 0);
      end
      if (de) begin
        int p = h - HB;
        logic eb = word_at(aline * WPL + p / W)[W - 1 - p % W];
        // R1 pixel order and line-boundary continuity
        chk(video == eb, "R1", int'(video), int'(eb));
      end else begin
        // R4 dark outside enable
        chk(video == 1'b0, "R4", int'(video), 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R6 quiet in reset
    chk(rd == 1'b0, "R6 rd", int'(rd), 0);
    chk(addr == '0, "R6 addr", int'(addr), 0);
    chk(video == 1'b0, "R6 video", int'(video), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int fr = 0; fr < 3; fr++) begin
      run_line(1'b1, 1'b0, 0, 0);
      run_line(1'b0, 1'b0, 0, 0);
      for (int l = 0; l < VL; l++) run_line(1'b0, 1'b1, l, l);
      run_line(1'b0, 1'b0, 0, VL);
    end
    @(negedge clk);
    sol = 1'b0; sof = 1'b0; de = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule